// File: doc/BRIEF.md
# Alternating-Bank Serial-to-Parallel Deserializer

This block takes a serial bit stream sampled on every rising edge of a fast clock and delivers parallel words at one eighth of that rate. Two shift banks of equal width take turns. A one-hot ring register that rotates each cycle decides which bank is enabled. While one bank collects incoming bits, the other holds the last complete word steady on the parallel output, where a slower consumer can read it.

A synchronous active-high clear holds the block idle until the upstream clock source reports lock. Releasing the clear starts word boundary counting: the first bit sampled after release becomes the most significant bit of the first word. A single-cycle strobe marks each new word. Clock generation, any crossing into a divided clock and alignment to framing patterns are left to the surrounding logic.

Top module: `pingpong_deser`

## Requirements
- R1: While rst_ni is low, and after it is released, word_o reads all zeros and word_valid_o reads 0 until the first word completes.
- R2: Bits are assembled MSB first: the bit sampled at the first edge of a word lands in word_o[WORD_W-1], and the bit sampled at the last edge lands in word_o[0].
- R3: word_valid_o is high for exactly one cycle per word. It rises after the WORD_W-th rising edge following release of clear or reset, and then after every further WORD_W edges. It is never high on two consecutive cycles.
- R4: Between strobes, word_o does not change: the bank holding the completed word is frozen while the other bank shifts.
- R5: Consecutive words alternate between the two banks, so a continuous stream is delivered with no lost or repeated bit across word boundaries.
- R6: While clear_i is high, word_valid_o stays 0 and no bits are captured, however long the clear lasts.
- R7: Asserting clear_i in the middle of a word discards the partial word, returns word_o to zero and restarts word counting, so the first bit after release is the MSB of the next word.
- R8: The pacing ring always has exactly one bit set, and it rotates by one position per unblocked cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous hold/clear, active high, held until the clock source is locked |
| ser_i | input | 1 | Serial data, sampled on every rising edge |
| word_o | output | WORD_W | Last completed word, MSB = first bit received |
| word_valid_o | output | 1 | One-cycle strobe marking a new word on word_o |

## Verification
If the ring loses its single set bit or carries two, the strobe disappears or fires at the wrong spacing. This shows up within one word time of WORD_W cycles. If the bank select goes wrong, word_o either changes between strobes or shows a bit-rotated or stale word at the next strobe. The bench streams every 8-bit value back to back and compares each strobe and each word against an arithmetic model. It also checks word_o stability on every cycle in between. Clears held both in mid-word and for long periods verify that alignment restarts at the first bit after release.

// File: rtl/deser_pkg.sv
package deser_pkg;
  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_sel_e;
endpackage

// File: rtl/deser_ring.sv
module deser_ring #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  output logic [WIDTH-1:0] ring_o,
  output logic             wrap_o
);
  logic [WIDTH-1:0] ring_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_q <= WIDTH'(1);
    end else if (clear_i) begin
      ring_q <= WIDTH'(1);
    end else begin
      ring_q <= {ring_q[WIDTH-2:0], ring_q[WIDTH-1]};
    end
  end

  assign ring_o = ring_q;
  assign wrap_o = ring_q[WIDTH-1];
endmodule

// File: rtl/deser_bank.sv
module deser_bank #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (clear_i) begin
      data_q <= '0;
    end else if (en_i) begin
      data_q <= {data_q[WIDTH-2:0], bit_i};
    end
  end

  assign data_o = data_q;
endmodule

// File: rtl/deser_steer.sv
module deser_steer
  import deser_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             wrap_i,
  input  logic [WIDTH-1:0] bank_a_i,
  input  logic [WIDTH-1:0] bank_b_i,
  output logic [1:0]       bank_en_o,
  output logic [WIDTH-1:0] word_o,
  output logic             valid_o
);
  bank_sel_e sel_q;
  logic      valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= BANK_A;
      valid_q <= 1'b0;
    end else if (clear_i) begin
      sel_q   <= BANK_A;
      valid_q <= 1'b0;
    end else begin
      valid_q <= wrap_i;
      if (wrap_i) sel_q <= (sel_q == BANK_A) ? BANK_B : BANK_A;
    end
  end

  assign bank_en_o[0] = !clear_i && (sel_q == BANK_A);
  assign bank_en_o[1] = !clear_i && (sel_q == BANK_B);
  // the idle bank holds the last full word
  assign word_o  = (sel_q == BANK_A) ? bank_b_i : bank_a_i;
  assign valid_o = valid_q;
endmodule

// File: rtl/pingpong_deser.sv
module pingpong_deser #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              ser_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);
  localparam int unsigned NUM_BANKS = 2;

  logic [WORD_W-1:0]    ring;
  logic                 wrap;
  logic [NUM_BANKS-1:0] bank_en;
  logic [WORD_W-1:0]    bank_data [NUM_BANKS];

  deser_ring #(.WIDTH(WORD_W)) u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .ring_o (ring),
    .wrap_o (wrap)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    deser_bank #(.WIDTH(WORD_W)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clear_i(clear_i),
      .en_i   (bank_en[g]),
      .bit_i  (ser_i),
      .data_o (bank_data[g])
    );
  end

  deser_steer #(.WIDTH(WORD_W)) u_steer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .wrap_i   (wrap),
    .bank_a_i (bank_data[0]),
    .bank_b_i (bank_data[1]),
    .bank_en_o(bank_en),
    .word_o   (word_o),
    .valid_o  (word_valid_o)
  );
endmodule

// File: rtl/pingpong_deser_chk.sv
module pingpong_deser_chk #(
  parameter int unsigned WORD_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic [WORD_W-1:0] word_o,
  input logic              word_valid_o,
  input logic [WORD_W-1:0] ring,
  input logic [1:0]        bank_en
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (cnt_q == CNT_W'(WORD_W - 1)) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assert_strobe_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);

  assert_strobe_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> (cnt_q == '0));

  assert_hold_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!word_valid_o && !$past(clear_i)) |-> $stable(word_o));

  assert_clear_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !word_valid_o);

  assert_clear_no_shift_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |-> (bank_en == 2'b00));

  assert_one_bank_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |-> ($countones(bank_en) == 1));

  assert_ring_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ring) == 1);
endmodule

bind pingpong_deser pingpong_deser_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clear_i     (clear_i),
  .word_o      (word_o),
  .word_valid_o(word_valid_o),
  .ring        (ring),
  .bank_en     (bank_en)
);

// File: tb/tb_pingpong_deser.sv
`timescale 1ns/1ps
module tb_pingpong_deser;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         clear_i = 1'b0;
  logic         ser_i = 1'b0;
  logic [W-1:0] word_o;
  logic         word_valid_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int           k = 0;
  logic [W-1:0] sh = '0;
  logic [W-1:0] exp_word = '0;
  logic         exp_valid = 1'b0;

  pingpong_deser #(.WORD_W(W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .ser_i(ser_i),
    .word_o(word_o), .word_valid_o(word_valid_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle; model updated from the requirements
  task automatic step(logic b, logic clr, string req);
    @(negedge clk_i);
    ser_i   = b;
    clear_i = clr;
    @(posedge clk_i);
    if (clr) begin
      k = 0; sh = '0; exp_word = '0; exp_valid = 1'b0;
    end else begin
      sh = {sh[W-2:0], b};
      exp_valid = ((k % W) == W - 1);
      if (exp_valid) exp_word = sh;
      k++;
    end
    #2;
    chk({req, " valid"}, W'(word_valid_o), W'(exp_valid));
    chk({req, " word"}, word_o, exp_word);
  endtask

  task automatic send_byte(logic [7:0] v, string req);
    for (int i = 7; i >= 0; i--) step(v[i], 1'b0, req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #3;
    chk("R1 reset word", word_o, '0);
    chk("R1 reset valid", W'(word_valid_o), '0);
    #20;
    rst_ni = 1'b1;
    // R6: long clear held as if waiting for lock
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, "R6 clear held");
    // R1: idle output before first word
    for (int i = 0; i < W - 1; i++) step(1'b1, 1'b0, "R1 before first word");
    step(1'b0, 1'b0, "R2 first word");
    // R2 R3 R4 R5: every byte value back to back
    for (int v = 0; v < 256; v++) send_byte(8'(v), "R5 sweep");
    // R2: specific patterns
    send_byte(8'h80, "R2 msb first");
    send_byte(8'h01, "R2 lsb last");
    // R7: clear in mid-word
    step(1'b1, 1'b0, "R7 partial");
    step(1'b0, 1'b0, "R7 partial");
    step(1'b1, 1'b0, "R7 partial");
    step(1'b0, 1'b1, "R7 clear");
    step(1'b0, 1'b1, "R7 clear");
    send_byte(8'hA5, "R7 realign");
    send_byte(8'h3C, "R7 realign");
    // R3: idle-high stream after realign
    for (int v = 0; v < 4; v++) send_byte(8'hFF, "R3 spacing");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule